// File: doc/BRIEF.md
# Sample-Pair Packing Capture FIFO

This block collects 16-bit converter samples from a simple valid/data strobe and packs each consecutive pair into one 32-bit word. The words go into a 512-word FIFO, which a host drains through a small 32-bit register window. If a capture ends on an odd sample, the leftover half is held in a packing register and reported in status. Software can then command it into the FIFO as a word of its own. A two-step flush command empties the FIFO and the packing register. While the flush is pending or running, a busy bit in status stays set.

The block is built from three state machines:
- **Packer.** Its states are `PK_EMPTY` and `PK_HOLD`. A sample moves it from `PK_EMPTY` to `PK_HOLD`. In `PK_HOLD`, a second sample writes the pair and returns it to `PK_EMPTY`. A stranded push writes the held sample alone and also returns it to `PK_EMPTY`, unless a new sample arrives in the same cycle; that sample is then held and the packer stays in `PK_HOLD`. A flush forces `PK_EMPTY`.
- **Flush controller.** Its states are `FL_IDLE`, `FL_ARMED` and `FL_BUSY`. A control write with bit 4 set moves it from `FL_IDLE` to `FL_ARMED`. A control write with bit 4 clear then moves it from `FL_ARMED` to `FL_BUSY`. After a fixed count of cycles in `FL_BUSY` it returns to `FL_IDLE`.
- **FIFO.** This is a plain counted ring buffer.

The host interface uses the following register addresses:
- 0 is the data word.
- 1 is control when written and status when read.
- 2 is the half-full threshold.

Top module: `adc_pair_fifo`

## Requirements
- R1: Two samples accepted in turn form one FIFO word, with the earlier sample in bits 31:16 and the later one in bits 15:0.
- R2: The FIFO holds 512 words. A word offered while it is full is discarded, and status bit 5 (overflow) becomes set and stays set until a flush.
- R3: Status bit 0 is 1 exactly while one unpaired sample sits in the packing register.
- R4: Writing control with bit 0 = 1 while an unpaired sample waits writes the word {sample, 16'h0000} to the FIFO and clears status bit 0.
- R5: Writing control bit 0 = 1 with no unpaired sample waiting has no effect: no word is written and status is unchanged.
- R6: Status bit 2 is 1 while at least one word can be read from address 0.
- R7: A read of address 0 while the FIFO is empty returns the last word successfully read and sets status bit 3 (underflow). Bit 3 stays set until a flush.
- R8: A control write with bit 4 = 1 sets status bit 4. A later control write with bit 4 = 0 starts a flush of 4 cycles. During the flush the FIFO and packing register empty and bits 3 and 5 clear. Status bit 4 clears when the flush ends.
- R9: Samples arriving during the 4 flush cycles are dropped.
- R10: Register 2 holds the half-full threshold in words and resets to 256. The output `half_full` is 1 while the word count is at least the threshold.
- R11: Register reads return data on `reg_rdata` one cycle after the `reg_rd` edge. A write to address 1 never appears in a read of address 1, which returns status. Register 2 reads back its written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Sample value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 data, 1 control/status, 2 threshold) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| half_full | output | 1 | Word count at or above threshold |

## Verification
A packer stuck in the wrong state would show up at once as a status bit 0 that disagrees with the number of samples sent. It would also show on the next data read, as swapped or merged halves. Wrong FIFO pointers or count would surface on the first read after filling: as a wrong word, as a false bit 2, or as a half-full flag that trips one word early or late. A flush controller that leaves its busy state too early or too late would change what a status read returns a few cycles after the second control write. It would also decide whether a sample sent during the flush survives, which the next status read exposes.

// File: rtl/adc_pair_pkg.sv
package adc_pair_pkg;
    typedef enum logic {PK_EMPTY, PK_HOLD} pk_state_e;
    typedef enum logic [1:0] {FL_IDLE, FL_ARMED, FL_BUSY} fl_state_e;

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_LEVEL = 2'd2;

    localparam int ST_STRANDED = 0;
    localparam int ST_AVAIL    = 2;
    localparam int ST_UNDER    = 3;
    localparam int ST_BUSY     = 4;
    localparam int ST_OVER     = 5;

    localparam int CT_PUSH  = 0;
    localparam int CT_FLUSH = 4;
endpackage

// File: rtl/pair_packer.sv
module pair_packer
    import adc_pair_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            smp_valid,
    input  logic [SW-1:0]   smp_data,
    input  logic            push_req,
    output logic            word_valid,
    output logic [2*SW-1:0] word_data,
    output logic            stranded
);
    pk_state_e     st_q, st_d;
    logic [SW-1:0] hold_q, hold_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PK_EMPTY;
            hold_q <= '0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
        end
    end

    always_comb begin
        st_d       = st_q;
        hold_d     = hold_q;
        word_valid = 1'b0;
        word_data  = '0;
        unique case (st_q)
            PK_EMPTY: begin
                if (smp_valid) begin
                    st_d   = PK_HOLD;
                    hold_d = smp_data;
                end
            end
            PK_HOLD: begin
                if (push_req) begin
                    word_valid = 1'b1;
                    word_data  = {hold_q, {SW{1'b0}}};
                    if (smp_valid) hold_d = smp_data;
                    else           st_d   = PK_EMPTY;
                end else if (smp_valid) begin
                    word_valid = 1'b1;
                    word_data  = {hold_q, smp_data};
                    st_d       = PK_EMPTY;
                end
            end
        endcase
        if (clear) begin
            st_d       = PK_EMPTY;
            word_valid = 1'b0;
        end
    end

    assign stranded = (st_q == PK_HOLD);

    // R1
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PK_HOLD && smp_valid && !push_req && !clear) |-> (word_data[2*SW-1:SW] == hold_q && word_valid));
endmodule

// File: rtl/flush_ctrl.sv
module flush_ctrl
    import adc_pair_pkg::*;
#(
    parameter int FLUSH_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_flush_bit,
    output logic clear,
    output logic busy
);
    localparam int CNTW = $clog2(FLUSH_CYCLES + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(FLUSH_CYCLES - 1);

    fl_state_e       st_q, st_d;
    logic [CNTW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            FL_IDLE: begin
                cnt_d = '0;
                if (ctl_wr && ctl_flush_bit) st_d = FL_ARMED;
            end
            FL_ARMED: begin
                cnt_d = '0;
                if (ctl_wr && !ctl_flush_bit) st_d = FL_BUSY;
            end
            FL_BUSY: begin
                if (cnt_q == LAST) begin
                    st_d  = FL_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = FL_IDLE;
        endcase
    end

    always_comb begin
        clear = (st_q == FL_BUSY);
        busy  = (st_q != FL_IDLE);
    end

    // R8
    flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FL_BUSY && cnt_q == LAST) |=> (st_q == FL_IDLE));
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty,
    output logic                       wr_drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_wr, do_rd;

    assign full    = (cnt_q == DEPTH_C);
    assign empty   = (cnt_q == '0);
    assign do_wr   = wr_en && !full && !clear;
    assign do_rd   = rd_en && !empty && !clear;
    assign wr_drop = wr_en && full && !clear;
    assign rd_data = mem[rptr_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) wptr_q <= wptr_q + 1'b1;
            if (do_rd) rptr_q <= rptr_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
        end
    end

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en && !clear) |=> (cnt_q == $past(cnt_q)));
    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/adc_pair_fifo.sv
module adc_pair_fifo
    import adc_pair_pkg::*;
#(
    parameter int SW           = 16,
    parameter int DEPTH_WORDS  = 512,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        half_full
);
    localparam int WW = 2 * SW;
    localparam int CW = $clog2(DEPTH_WORDS) + 1;
    localparam logic [CW-1:0] LEVEL_RST = CW'(DEPTH_WORDS / 2);

    logic          clear, busy, stranded;
    logic          ctl_wr, push_req, pk_valid;
    logic [WW-1:0] pk_data, fifo_rd_data;
    logic [CW-1:0] fifo_count, level_q;
    logic          full, empty, wr_drop, data_rd;
    logic          under_q, over_q;
    logic [31:0]   last_q, status_w;
    logic          unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign ctl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign push_req = ctl_wr && reg_wdata[CT_PUSH];
    assign data_rd  = reg_rd && (reg_addr == ADDR_DATA);

    flush_ctrl #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .ctl_flush_bit(reg_wdata[CT_FLUSH]), .clear(clear), .busy(busy)
    );

    pair_packer #(.SW(SW)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .smp_valid(smp_valid && !clear), .smp_data(smp_data[SW-1:0]),
        .push_req(push_req), .word_valid(pk_valid), .word_data(pk_data),
        .stranded(stranded)
    );

    word_fifo #(.WIDTH(WW), .DEPTH(DEPTH_WORDS)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .wr_en(pk_valid), .wr_data(pk_data),
        .rd_en(data_rd), .rd_data(fifo_rd_data),
        .count(fifo_count), .full(full), .empty(empty), .wr_drop(wr_drop)
    );

    always_comb begin
        status_w              = '0;
        status_w[ST_STRANDED] = stranded;
        status_w[ST_AVAIL]    = !empty;
        status_w[ST_UNDER]    = under_q;
        status_w[ST_BUSY]     = busy;
        status_w[ST_OVER]     = over_q;
    end

    assign half_full = (fifo_count >= level_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= LEVEL_RST;
            under_q   <= 1'b0;
            over_q    <= 1'b0;
            last_q    <= '0;
            reg_rdata <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_LEVEL) level_q <= reg_wdata[CW-1:0];
            if (clear) begin
                under_q <= 1'b0;
                over_q  <= 1'b0;
            end else begin
                if (data_rd && empty) under_q <= 1'b1;
                if (wr_drop)          over_q  <= 1'b1;
            end
            if (reg_rd) begin
                unique case (reg_addr)
                    ADDR_DATA: begin
                        if (!empty && !clear) begin
                            reg_rdata <= 32'(fifo_rd_data);
                            last_q    <= 32'(fifo_rd_data);
                        end else begin
                            reg_rdata <= last_q;
                        end
                    end
                    ADDR_CTRL:  reg_rdata <= status_w;
                    ADDR_LEVEL: reg_rdata <= 32'(level_q);
                    default:    reg_rdata <= '0;
                endcase
            end
        end
    end

    // R3
    stranded_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stranded) |-> $past(smp_valid));
    // R4
    push_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && stranded && !clear) |-> (pk_valid && pk_data[SW-1:0] == '0));
    // R5
    push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !stranded) |-> !pk_valid);
    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fifo_count == '0 && !stranded && !under_q && !over_q));
    // R9
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !pk_valid);
endmodule

// File: tb/tb_adc_pair_fifo.sv
module tb_adc_pair_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        half_full;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_pair_fifo dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .half_full(half_full)
    );

    localparam logic [31:0] PAIRS [6] = '{
        32'h1234_5678, 32'hFFFF_0000, 32'h0000_FFFF,
        32'hA5A5_5A5A, 32'h8001_7FFE, 32'h0F0F_F0F0
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push(input logic [15:0] s);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = s;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_flush();
        wr_reg(2'd1, 32'h10);
        wr_reg(2'd1, 32'h00);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_reg(2'd1, v);
        check(v == 32'h0, "R6 reset status", v, 32'h0);
        check(half_full == 1'b0, "R10 reset half_full", {31'd0, half_full}, 32'h0);
        rd_reg(2'd2, v);
        check(v == 32'd256, "R10 R11 reset level", v, 32'd256);

        // R5: push with nothing held; R11 control write not read back
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, v);
        check(v == 32'h0, "R5 R11 idle push", v, 32'h0);

        // R1 vector table
        foreach (PAIRS[i]) begin
            push(PAIRS[i][31:16]);
            push(PAIRS[i][15:0]);
        end
        rd_reg(2'd1, v);
        check(v == 32'h4, "R6 avail after pairs", v, 32'h4);
        for (int i = 0; i < 6; i++) begin
            rd_reg(2'd0, v);
            check(v == PAIRS[i], "R1 pair word", v, PAIRS[i]);
        end
        rd_reg(2'd1, v);
        check(v == 32'h0, "R6 empty after drain", v, 32'h0);

        // R3 / R4 stranded
        push(16'hBEEF);
        rd_reg(2'd1, v);
        check(v == 32'h1, "R3 stranded flag", v, 32'h1);
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, v);
        check(v == 32'h4, "R4 stranded pushed", v, 32'h4);
        rd_reg(2'd0, v);
        check(v == 32'hBEEF_0000, "R4 stranded word", v, 32'hBEEF_0000);

        // R7 underflow
        rd_reg(2'd0, v);
        check(v == 32'hBEEF_0000, "R7 underflow last value", v, 32'hBEEF_0000);
        rd_reg(2'd1, v);
        check(v == 32'h8, "R7 underflow sticky", v, 32'h8);

        // R8 flush, R9 drop during flush
        push(16'h1111); push(16'h2222); push(16'h3333);
        wr_reg(2'd1, 32'h10);
        rd_reg(2'd1, v);
        check(v == 32'h1D, "R8 armed busy", v, 32'h1D);
        wr_reg(2'd1, 32'h00);
        push(16'h4444);
        rd_reg(2'd1, v);
        check(v[4] == 1'b1, "R8 busy during flush", v, 32'h10);
        repeat (6) @(negedge clk);
        rd_reg(2'd1, v);
        check(v == 32'h0, "R8 R9 after flush", v, 32'h0);

        // R10 half-full threshold
        wr_reg(2'd2, 32'd3);
        rd_reg(2'd2, v);
        check(v == 32'd3, "R11 level readback", v, 32'd3);
        push(16'h1); push(16'h2); push(16'h3); push(16'h4);
        check(half_full == 1'b0, "R10 below level", {31'd0, half_full}, 32'h0);
        push(16'h5); push(16'h6);
        check(half_full == 1'b1, "R10 at level", {31'd0, half_full}, 32'h1);
        rd_reg(2'd0, v);
        check(half_full == 1'b0, "R10 after read", {31'd0, half_full}, 32'h0);
        do_flush();
        wr_reg(2'd2, 32'd256);

        // R2 fill and overflow
        for (int k = 0; k < 1024; k++) push(16'(k));
        push(16'hDEAD); push(16'hD00D);
        rd_reg(2'd1, v);
        check(v == 32'h24, "R2 overflow sticky", v, 32'h24);
        bad = 0;
        for (int k = 0; k < 512; k++) begin
            rd_reg(2'd0, v);
            if (v != {16'(2*k), 16'(2*k+1)}) bad++;
        end
        check(bad == 0, "R2 full contents", 32'(bad), 32'h0);
        rd_reg(2'd1, v);
        check(v == 32'h20, "R2 drained no extra word", v, 32'h20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule